// File: doc/BRIEF.md
# Strided Raw Copy DMA Engine

This block moves a programmed number of bytes from a source region of memory to a destination region without changing the data. Each side is walked in 16-byte chunks. A side takes a run of "width" chunks, then jumps over "gap" chunks, then takes the next run. Because source and destination have their own width/gap pair, software can copy a sub-rectangle from a buffer of one pitch into a buffer of another pitch in one transfer.

Software writes the two base addresses, the byte total and the two width/gap words through a small register port, then writes the start bit. The engine then drives a simple memory master port. Every 16-byte beat is one read, followed by one write of the same data. When the last beat has been written, the busy bit drops and the done bit rises.

The controller has six states:
- `ST_IDLE` waits for a start.
- `ST_PREP` decides whether there is anything to copy.
- `ST_RD` requests a read.
- `ST_RWAIT` waits for the read data.
- `ST_WR` requests the write.
- `ST_DONE` marks completion.

Transitions:
- IDLE→PREP on a start write.
- PREP→DONE on a zero configuration, otherwise PREP→RD.
- RD→RWAIT on grant.
- RWAIT→WR on read-data valid.
- WR→RD on grant when beats remain, or WR→DONE on grant of the last beat.
- DONE→IDLE unconditionally.

Top module: `strided_copy_dma`

## Requirements
- R1: After reset the control word reads 0 (not busy, not done) and `mem_req` is low.
- R2: Register word index 5 is the control word. Writing it with bit 0 set while idle starts a transfer and clears bit 8. While the transfer runs, bit 0 reads 1. On completion, bit 0 reads 0 and bit 8 reads 1.
- R3: Word index 0 (source) and word index 1 (destination) hold byte address >> 3. The first read or write on a side is at the register value shifted left by 3.
- R4: Word index 2 holds the byte total. The number of 16-byte beats moved is the total divided by 16, rounded up.
- R5: Word index 3 (source) and word index 4 (destination) hold the width in bits 15:0 and the gap in bits 31:16, both counted in 16-byte chunks. After each run of width chunks, that side's address skips gap chunks. Skipped chunks do not count toward the total.
- R6: The source and destination walkers advance independently, so their line boundaries need not coincide.
- R7: Each write carries exactly the data returned by the matching read, unchanged.
- R8: A byte total of zero, or a width of zero on either side, finishes the transfer with done set and no memory access.
- R9: Writes to word indices 0 to 4 are ignored while busy.
- R10: `mem_req` stays high with a stable address and direction until `mem_gnt`. A read beat completes on `mem_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register word index for writes |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register word index for reads |
| cfg_rdata | output | 32 | Register read data (combinational) |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Byte address of the 16-byte beat |
| mem_wdata | output | 128 | Write data |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 128 | Read data |

## Verification
The embedded properties watch, on every cycle:
- that a stalled request keeps its address and direction;
- that configuration registers stay frozen while busy;
- that each walker moves one chunk per step, or one chunk plus the gap at a line end;
- that the beat counter never underflows;
- that a zero configuration goes straight to completion.

The bench scenarios are needed to show the things no single-cycle property captures:
- the total beat count for an unaligned byte total;
- the full address sequences of two independent width/gap patterns;
- that every written beat equals the data read for it.

// File: rtl/strd_pkg.sv
package strd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_RD,
        ST_RWAIT,
        ST_WR,
        ST_DONE
    } strd_state_e;

    localparam logic [2:0] IDX_SRC  = 3'd0;
    localparam logic [2:0] IDX_DST  = 3'd1;
    localparam logic [2:0] IDX_SIZE = 3'd2;
    localparam logic [2:0] IDX_IN   = 3'd3;
    localparam logic [2:0] IDX_OUT  = 3'd4;
    localparam logic [2:0] IDX_CTRL = 3'd5;
endpackage

// File: rtl/strd_walker.sv
module strd_walker #(
    parameter int AW      = 32,
    parameter int FW      = 16,
    parameter int BEAT_LG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic [FW-1:0] width,
    input  logic [FW-1:0] gap,
    input  logic          step,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] CHUNK = AW'(1) << BEAT_LG;

    logic [FW-1:0] col;
    logic          line_end;
    logic [AW-1:0] skip;

    assign line_end = (col == width - FW'(1));
    assign skip     = (AW'(gap) + AW'(1)) << BEAT_LG;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr <= '0;
            col  <= '0;
        end else if (load) begin
            addr <= base;
            col  <= '0;
        end else if (step) begin
            if (line_end) begin
                col  <= '0;
                addr <= addr + skip;
            end else begin
                col  <= col + FW'(1);
                addr <= addr + CHUNK;
            end
        end
    end

    AST_WALK_INLINE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !line_end) |=> (addr == $past(addr) + CHUNK)); // R5
    AST_WALK_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && line_end) |=> (addr == $past(addr) + $past(skip))); // R5
endmodule

// File: rtl/strd_beat_count.sv
module strd_beat_count #(
    parameter int SW      = 32,
    parameter int BEAT_LG = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [SW-1:0] size,
    input  logic          dec,
    output logic          last,
    output logic          empty
);
    localparam int CW = SW - BEAT_LG + 1;

    logic [SW:0]   rounded;
    logic [CW-1:0] cnt;

    assign rounded = {1'b0, size} + (SW+1)'((1 << BEAT_LG) - 1);
    assign last    = (cnt == CW'(1));
    assign empty   = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= rounded[SW:BEAT_LG];
        end else if (dec) begin
            cnt <= cnt - CW'(1);
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> !empty); // R4
endmodule

// File: rtl/strd_ctrl_fsm.sv
module strd_ctrl_fsm
    import strd_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic        zero_cfg,
    input  logic        gnt,
    input  logic        rvalid,
    input  logic        last,
    output strd_state_e state,
    output logic        req,
    output logic        we,
    output logic        load,
    output logic        step,
    output logic        capture,
    output logic        finish
);
    strd_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (start) nxt = ST_PREP;
            ST_PREP:  nxt = zero_cfg ? ST_DONE : ST_RD;
            ST_RD:    if (gnt) nxt = ST_RWAIT;
            ST_RWAIT: if (rvalid) nxt = ST_WR;
            ST_WR:    if (gnt) nxt = last ? ST_DONE : ST_RD;
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        req     = 1'b0;
        we      = 1'b0;
        load    = 1'b0;
        step    = 1'b0;
        capture = 1'b0;
        finish  = 1'b0;
        unique case (state)
            ST_IDLE:  load = start;
            ST_PREP:  ;
            ST_RD:    req = 1'b1;
            ST_RWAIT: capture = rvalid;
            ST_WR: begin
                req  = 1'b1;
                we   = 1'b1;
                step = gnt;
            end
            ST_DONE:  finish = 1'b1;
            default:  ;
        endcase
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !gnt) |=> (req && $stable(we))); // R10
    AST_ZERO_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PREP && zero_cfg) |=> (state == ST_DONE)); // R8
endmodule

// File: rtl/strided_copy_dma.sv
module strided_copy_dma
    import strd_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 128,
    parameter int RW = 32,
    parameter int FW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_waddr,
    input  logic [RW-1:0] cfg_wdata,
    input  logic [2:0]    cfg_raddr,
    output logic [RW-1:0] cfg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic          mem_gnt,
    input  logic          mem_rvalid,
    input  logic [DW-1:0] mem_rdata
);
    localparam int BEAT_LG = $clog2(DW / 8);
    localparam int BW      = AW - 3;

    logic [BW-1:0] src_q, dst_q;
    logic [RW-1:0] size_q;
    logic [FW-1:0] in_w_q, in_g_q, out_w_q, out_g_q;
    logic          done_q;
    logic [DW-1:0] buf_q;

    strd_state_e state;
    logic busy, start, zero_cfg, load, step, capture, finish, last, empty;
    logic [AW-1:0] src_addr, dst_addr;

    assign busy     = (state != ST_IDLE);
    assign start    = cfg_we && (cfg_waddr == IDX_CTRL) && cfg_wdata[0] && !busy;
    assign zero_cfg = empty || (in_w_q == '0) || (out_w_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            dst_q   <= '0;
            size_q  <= '0;
            in_w_q  <= '0;
            in_g_q  <= '0;
            out_w_q <= '0;
            out_g_q <= '0;
        end else if (cfg_we && !busy) begin
            unique case (cfg_waddr)
                IDX_SRC:  src_q  <= cfg_wdata[BW-1:0];
                IDX_DST:  dst_q  <= cfg_wdata[BW-1:0];
                IDX_SIZE: size_q <= cfg_wdata;
                IDX_IN:   {in_g_q, in_w_q}   <= cfg_wdata[2*FW-1:0];
                IDX_OUT:  {out_g_q, out_w_q} <= cfg_wdata[2*FW-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      done_q <= 1'b0;
        else if (load)   done_q <= 1'b0;
        else if (finish) done_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       buf_q <= '0;
        else if (capture) buf_q <= mem_rdata;
    end

    always_comb begin
        cfg_rdata = '0;
        unique case (cfg_raddr)
            IDX_SRC:  cfg_rdata = RW'(src_q);
            IDX_DST:  cfg_rdata = RW'(dst_q);
            IDX_SIZE: cfg_rdata = size_q;
            IDX_IN:   cfg_rdata = RW'({in_g_q, in_w_q});
            IDX_OUT:  cfg_rdata = RW'({out_g_q, out_w_q});
            IDX_CTRL: begin
                cfg_rdata[0] = busy;
                cfg_rdata[8] = done_q;
            end
            default:  cfg_rdata = '0;
        endcase
    end

    strd_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .zero_cfg(zero_cfg),
        .gnt(mem_gnt), .rvalid(mem_rvalid), .last(last), .state(state),
        .req(mem_req), .we(mem_we), .load(load), .step(step),
        .capture(capture), .finish(finish)
    );

    strd_beat_count #(.SW(RW), .BEAT_LG(BEAT_LG)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .size(size_q),
        .dec(step), .last(last), .empty(empty)
    );

    strd_walker #(.AW(AW), .FW(FW), .BEAT_LG(BEAT_LG)) u_src_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .base({src_q, 3'b000}),
        .width(in_w_q), .gap(in_g_q), .step(step), .addr(src_addr)
    );

    strd_walker #(.AW(AW), .FW(FW), .BEAT_LG(BEAT_LG)) u_dst_walk (
        .clk(clk), .rst_n(rst_n), .load(load), .base({dst_q, 3'b000}),
        .width(out_w_q), .gap(out_g_q), .step(step), .addr(dst_addr)
    );

    assign mem_addr  = mem_we ? dst_addr : src_addr;
    assign mem_wdata = buf_q;

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> ($stable(src_q) && $stable(dst_q) && $stable(size_q)
            && $stable(in_w_q) && $stable(out_w_q) && $stable(in_g_q) && $stable(out_g_q))); // R9
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> $stable(mem_addr)); // R10
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !busy); // R2
    AST_WDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we && !mem_gnt) |=> $stable(mem_wdata)); // R7
endmodule

// File: tb/strided_copy_dma_test.sv
module strided_copy_dma_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cfg_we = 1'b0;
    logic [2:0]   cfg_waddr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic [2:0]   cfg_raddr = '0;
    logic [31:0]  cfg_rdata;
    logic         mem_req, mem_we;
    logic [31:0]  mem_addr;
    logic [127:0] mem_wdata;
    logic         mem_gnt;
    logic         mem_rvalid = 1'b0;
    logic [127:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    strided_copy_dma uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_waddr(cfg_waddr),
        .cfg_wdata(cfg_wdata), .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata)
    );

    typedef struct packed {
        logic [31:0] src, dst, size;
        logic [15:0] iw, ig, ow, og;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{32'h20, 32'h100, 32'd64,  16'd4, 16'd0, 16'd4, 16'd0},
        '{32'h40, 32'h200, 32'd100, 16'd3, 16'd2, 16'd2, 16'd1},
        '{32'h60, 32'h300, 32'd48,  16'd1, 16'd3, 16'd5, 16'd0},
        '{32'h31, 32'h401, 32'd33,  16'd2, 16'd0, 16'd1, 16'd1}
    };

    int n_checks = 0, n_fail = 0;
    int n_rd = 0, n_wr = 0;
    logic [31:0]  rd_log [64];
    logic [31:0]  wr_log [64];
    logic [127:0] wd_log [64];
    logic         gnt_mode = 1'b0;
    logic [7:0]   lfsr = 8'h5B;
    bit           finished = 1'b0;

    function automatic logic [127:0] pat(input logic [31:0] a);
        return {a, ~a, a ^ 32'h5A5A_5A5A, a + 32'h1357};
    endfunction

    function automatic logic [31:0] walk(input logic [31:0] base, input int w, input int g, input int k);
        return base + 32'(16 * ((k / w) * (w + g) + (k % w)));
    endfunction

    assign mem_gnt = gnt_mode ? (lfsr[0] | lfsr[3]) : 1'b1;

    always @(posedge clk) begin
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_rvalid <= 1'b0;
        if (rst_n && mem_req && mem_gnt) begin
            if (mem_we) begin
                if (n_wr < 64) begin
                    wr_log[n_wr] = mem_addr;
                    wd_log[n_wr] = mem_wdata;
                end
                n_wr = n_wr + 1;
            end else begin
                if (n_rd < 64) rd_log[n_rd] = mem_addr;
                n_rd = n_rd + 1;
                mem_rvalid <= 1'b1;
                mem_rdata  <= pat(mem_addr);
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [31:0] d);
        cfg_raddr = a;
        #1;
        d = cfg_rdata;
    endtask

    task automatic wait_idle(output logic [31:0] ctrl);
        ctrl = 32'h1;
        for (int i = 0; i < 2000 && ctrl[0]; i++) begin
            @(negedge clk);
            rd_reg(3'd5, ctrl);
        end
    endtask

    task automatic program_vec(input vec_t v);
        wr_reg(3'd0, v.src);
        wr_reg(3'd1, v.dst);
        wr_reg(3'd2, v.size);
        wr_reg(3'd3, {v.ig, v.iw});
        wr_reg(3'd4, {v.og, v.ow});
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        logic [31:0] ctrl;
        int beats, bad_a, bad_d;
        n_rd = 0; n_wr = 0;
        program_vec(v);
        wr_reg(3'd5, 32'h1);
        wait_idle(ctrl);
        beats = (int'(v.size) + 15) / 16;
        check({tag, " R2 done"}, ctrl & 32'h101, 32'h100);
        check({tag, " R4 beats"}, 32'(n_wr), 32'(beats));
        bad_a = 0; bad_d = 0;
        for (int k = 0; k < beats && k < n_wr && k < n_rd; k++) begin
            if (rd_log[k] !== walk(v.src << 3, int'(v.iw), int'(v.ig), k)) bad_a++;
            if (wr_log[k] !== walk(v.dst << 3, int'(v.ow), int'(v.og), k)) bad_a++;
            if (wd_log[k] !== pat(rd_log[k])) bad_d++;
        end
        check({tag, " R3 R5 R6 address walk"}, 32'(bad_a), 32'd0);
        check({tag, " R7 data"}, 32'(bad_d), 32'd0);
    endtask

    initial begin
        int cyc = 0;
        while (!finished) begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
                $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
                $finish;
            end
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rd_reg(3'd5, d);
        check("R1 ctrl after reset", d, 32'h0);
        check("R1 mem_req after reset", {31'd0, mem_req}, 32'h0);
        rst_n = 1'b1;

        // vector table, once with full grant and once with stalls
        for (int m = 0; m < 2; m++) begin
            gnt_mode = m[0];
            for (int i = 0; i < 4; i++) run_vec(VECS[i], m == 0 ? "vec" : "vec stall");
        end

        // R8: zero size
        gnt_mode = 1'b0;
        n_rd = 0; n_wr = 0;
        program_vec('{32'h20, 32'h100, 32'd0, 16'd4, 16'd0, 16'd4, 16'd0});
        wr_reg(3'd5, 32'h1);
        wait_idle(d);
        check("R8 zero size done", d & 32'h101, 32'h100);
        check("R8 zero size no access", 32'(n_rd + n_wr), 32'd0);

        // R8: zero output width
        n_rd = 0; n_wr = 0;
        program_vec('{32'h20, 32'h100, 32'd64, 16'd4, 16'd0, 16'd0, 16'd2});
        wr_reg(3'd5, 32'h1);
        wait_idle(d);
        check("R8 zero width done", d & 32'h101, 32'h100);
        check("R8 zero width no access", 32'(n_rd + n_wr), 32'd0);

        // R9 and R2: writes ignored while busy, busy visible
        gnt_mode = 1'b1;
        n_rd = 0; n_wr = 0;
        program_vec(VECS[1]);
        wr_reg(3'd5, 32'h1);
        rd_reg(3'd5, d);
        check("R2 busy while running", d & 32'h101, 32'h1);
        wr_reg(3'd0, 32'hDEAD);
        wr_reg(3'd2, 32'd16);
        wait_idle(d);
        rd_reg(3'd0, d);
        check("R9 source kept", d, VECS[1].src);
        rd_reg(3'd2, d);
        check("R9 size kept", d, VECS[1].size);
        check("R9 beat count kept", 32'(n_wr), 32'd7);

        // R2: restart clears done
        gnt_mode = 1'b0;
        wr_reg(3'd5, 32'h1);
        rd_reg(3'd5, d);
        check("R2 restart clears done", d & 32'h100, 32'h0);
        wait_idle(d);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        finished = 1'b1;
        $finish;
    end
endmodule